// File: doc/BRIEF.md
# Fixed-Cycle Two-Road Crossing Light Controller

This block drives the signal lamps of a crossing where two roads meet. Each road has one vehicle signal head and one pedestrian signal head, and each head is shown as a 3-bit lamp vector. The controller runs through an unchanging cycle of eight phases, one after the other. Every phase lasts the same dwell time, and the cycle repeats without end. No sensor, button or other input changes the order or the timing. Only the clock and a synchronous reset go into the block.

The cycle starts with an all-red clearance for road A. Road A then gets a red-plus-amber warning, then green with its pedestrians allowed to walk, then an amber-plus-green stop phase. After another all-red clearance, road B runs the same four steps. The dwell time is set by two parameters, the clock frequency in hertz and the number of milliseconds per phase, so one counter covers both full-speed use and a few-cycle dwell in simulation. All lamp outputs come straight from registers.

Top module: `xlight_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are vehA=100, pedA=010, vehB=100, pedB=010. They stay at these values for as long as reset is held.
- R2: The road A phases follow the first all-red phase in this order. First vehA=110 with pedA=010. Then vehA=001 with pedA=001. Then vehA=011 with pedA=010. Through all three, vehB=100 and pedB=010.
- R3: The road B phases follow the second all-red phase in the same way. First vehB=110 with pedB=010. Then vehB=001 with pedB=001. Then vehB=011 with pedB=010. Through all three, vehA=100 and pedA=010.
- R4: Between the road A stop phase and the road B warning phase there is an all-red phase: vehA=100, pedA=010, vehB=100, pedB=010.
- R5: After the road B stop phase, the controller returns to the first all-red phase and repeats the eight-phase cycle forever.
- R6: Each phase holds for exactly DWELL = (CLK_HZ/1000)*PHASE_MS clock cycles. The first change of phase happens DWELL rising edges after the first edge at which `rst` is low.
- R7: The outputs change only on the clock edge where the phase advances. They stay constant on every other edge.
- R8: A pedestrian lamp shows walk (001) only while its own road's vehicle lamp shows green (001). The two pedestrian lamps never show walk at the same time.
- R9: A reset pulse in the middle of the cycle returns the controller to the first all-red phase. That phase is then held for a full DWELL after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vehA | output | 3 | Road A vehicle lamps (red, amber, green from MSB to LSB) |
| pedA | output | 3 | Road A pedestrian lamps (010 stop, 001 walk) |
| vehB | output | 3 | Road B vehicle lamps (red, amber, green from MSB to LSB) |
| pedB | output | 3 | Road B pedestrian lamps (010 stop, 001 walk) |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a dwell. There, the counter is part-way through a phase other than the first one. The stimulus runs two full cycles and then pulls reset when the controller is one cycle into the road A green phase. It then checks that the first all-red phase lasts a whole dwell again before the warning phase appears. A shrunken dwell of four cycles keeps the run short, and the output is compared on every cycle, so an early or late phase change shows up.

// File: rtl/xlight_pkg.sv
package xlight_pkg;

  // Bit 2 selects the road, bits 1:0 the stage within that road's turn.
  typedef enum logic [2:0] {
    PH_ALLRED_A = 3'd0,
    PH_PREP_A   = 3'd1,
    PH_GO_A     = 3'd2,
    PH_STOP_A   = 3'd3,
    PH_ALLRED_B = 3'd4,
    PH_PREP_B   = 3'd5,
    PH_GO_B     = 3'd6,
    PH_STOP_B   = 3'd7
  } phase_t;

  localparam logic [2:0] VEH_RED  = 3'b100;
  localparam logic [2:0] VEH_PREP = 3'b110;
  localparam logic [2:0] VEH_GO   = 3'b001;
  localparam logic [2:0] VEH_STOP = 3'b011;
  localparam logic [2:0] PED_STOP = 3'b010;
  localparam logic [2:0] PED_WALK = 3'b001;

  typedef struct packed {
    logic [2:0] vehA;
    logic [2:0] pedA;
    logic [2:0] vehB;
    logic [2:0] pedB;
  } lamps_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic   clearCnt;
    logic   loadLamps;
    phase_t loadPhase;
  } strobes_t;

  function automatic phase_t nextPhase(input phase_t p);
    phase_t n;
    case (p)
      PH_ALLRED_A: n = PH_PREP_A;
      PH_PREP_A:   n = PH_GO_A;
      PH_GO_A:     n = PH_STOP_A;
      PH_STOP_A:   n = PH_ALLRED_B;
      PH_ALLRED_B: n = PH_PREP_B;
      PH_PREP_B:   n = PH_GO_B;
      PH_GO_B:     n = PH_STOP_B;
      default:     n = PH_ALLRED_A;
    endcase
    return n;
  endfunction

  function automatic lamps_t encodeLamps(input phase_t p);
    lamps_t     l;
    logic [2:0] veh;
    logic [2:0] ped;
    case (p[1:0])
      2'd1:    begin veh = VEH_PREP; ped = PED_STOP; end
      2'd2:    begin veh = VEH_GO;   ped = PED_WALK; end
      2'd3:    begin veh = VEH_STOP; ped = PED_STOP; end
      default: begin veh = VEH_RED;  ped = PED_STOP; end
    endcase
    l.vehA = VEH_RED;
    l.pedA = PED_STOP;
    l.vehB = VEH_RED;
    l.pedB = PED_STOP;
    if (p[2]) begin
      l.vehB = veh;
      l.pedB = ped;
    end else begin
      l.vehA = veh;
      l.pedA = ped;
    end
    return l;
  endfunction

endpackage

// File: rtl/xlight_seq.sv
module xlight_seq
  import xlight_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     dwellDone,
  output strobes_t strobes
);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_ALLRED_A;
    end else if (dwellDone) begin
      phase <= nextPhase(phase);
    end
  end

  always_comb begin
    strobes.clearCnt  = rst | dwellDone;
    strobes.loadLamps = rst | dwellDone;
    strobes.loadPhase = rst ? PH_ALLRED_A : nextPhase(phase);
  end

  // R5: the last phase wraps to the first.
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STOP_B && dwellDone) |=> (phase == PH_ALLRED_A));

  // R6: the phase holds while the dwell is running.
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !dwellDone |=> $stable(phase));

  // R1: reset lands in the first all-red phase.
  a_r1_reset_phase: assert property (@(posedge clk)
    rst |=> (phase == PH_ALLRED_A));

endmodule

// File: rtl/xlight_dp.sv
module xlight_dp
  import xlight_pkg::*;
#(
  parameter int DWELL = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  strobes_t strobes,
  output logic     dwellDone,
  output lamps_t   lamps
);

  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (strobes.clearCnt) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign dwellDone = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (strobes.loadLamps) begin
      lamps <= encodeLamps(strobes.loadPhase);
    end
  end

  // R6: the dwell counter never passes its last value.
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R7: the lamps hold unless a load strobe arrives.
  a_r7_stable: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadLamps |=> $stable(lamps));

  // R8: walk only with the own road on green, never both roads.
  a_r8_walk_a: assert property (@(posedge clk) disable iff (rst)
    (lamps.pedA == PED_WALK) |-> (lamps.vehA == VEH_GO));
  a_r8_walk_b: assert property (@(posedge clk) disable iff (rst)
    (lamps.pedB == PED_WALK) |-> (lamps.vehB == VEH_GO));
  a_r8_single_walk: assert property (@(posedge clk) disable iff (rst)
    !(lamps.pedA == PED_WALK && lamps.pedB == PED_WALK));

  // R1: reset drives the all-red pattern onto the lamps.
  a_r1_reset_lamps: assert property (@(posedge clk)
    rst |=> (lamps == 12'b100_010_100_010));

endmodule

// File: rtl/xlight_ctrl.sv
module xlight_ctrl
  import xlight_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int PHASE_MS = 1000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] vehA,
  output logic [2:0] pedA,
  output logic [2:0] vehB,
  output logic [2:0] pedB
);

  localparam int TICKS_PER_MS = CLK_HZ / 1000;
  localparam int DWELL        = TICKS_PER_MS * PHASE_MS;

  strobes_t strobes;
  logic     dwellDone;
  lamps_t   lamps;

  xlight_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .dwellDone (dwellDone),
    .strobes   (strobes)
  );

  xlight_dp #(.DWELL(DWELL)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .dwellDone (dwellDone),
    .lamps     (lamps)
  );

  assign vehA = lamps.vehA;
  assign pedA = lamps.pedA;
  assign vehB = lamps.vehB;
  assign pedB = lamps.pedB;

endmodule

// File: tb/xlight_ctrl_tb_top.sv
module xlight_ctrl_tb_top;

  localparam int CLK_HZ   = 4000;
  localparam int PHASE_MS = 1;
  localparam int D        = (CLK_HZ / 1000) * PHASE_MS;

  // Expected {vehA, pedA, vehB, pedB} per phase.
  localparam logic [11:0] EXP [8] = '{
    12'b100_010_100_010,
    12'b110_010_100_010,
    12'b001_001_100_010,
    12'b011_010_100_010,
    12'b100_010_100_010,
    12'b100_010_110_010,
    12'b100_010_001_001,
    12'b100_010_011_010
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] vehA, pedA, vehB, pedB;
  int         nChecks = 0;
  int         nFail   = 0;

  always #10 clk = ~clk;

  xlight_ctrl #(.CLK_HZ(CLK_HZ), .PHASE_MS(PHASE_MS)) dut_i (
    .clk  (clk),
    .rst  (rst),
    .vehA (vehA),
    .pedA (pedA),
    .vehB (vehB),
    .pedB (pedB)
  );

  task automatic check(input string tag, input logic [11:0] exp);
    logic [11:0] got;
    got = {vehA, pedA, vehB, pedB};
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic checkWalk();
    logic ok;
    ok = (pedA != 3'b001 || vehA == 3'b001) &&
         (pedB != 3'b001 || vehB == 3'b001) &&
         !(pedA == 3'b001 && pedB == 3'b001);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL R8: got pedA=%b vehA=%b pedB=%b vehB=%b expected walk only on own green",
               pedA, vehA, pedB, vehB);
    end
  endtask

  function automatic string tagFor(input int idx);
    string t;
    case (idx)
      0:       t = "R5 wrap to all-red";
      1, 2, 3: t = "R2 road A phase";
      4:       t = "R4 mid all-red";
      default: t = "R3 road B phase";
    endcase
    return t;
  endfunction

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", EXP[0]);
    @(negedge clk);
    check("R1 reset held", EXP[0]);
    rst = 1'b0;

    // Two full cycles, one sample per clock.
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < D; j++) begin
        if (j == 0) check(tagFor(k % 8), EXP[k % 8]);
        else        check("R6 R7 dwell hold", EXP[k % 8]);
        checkWalk();
        @(negedge clk);
      end
    end

    // Move into the middle of the road A green phase.
    repeat (2 * D + 1) @(negedge clk);
    check("R9 pre-reset mid green", EXP[2]);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid-cycle reset", EXP[0]);
    rst = 1'b0;
    for (int j = 0; j < D; j++) begin
      check("R9 full dwell after reset", EXP[0]);
      @(negedge clk);
    end
    check("R9 advance after reset dwell", EXP[1]);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R6 watchdog: got no finish expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule